// File: doc/BRIEF.md
# Transmit Slip Buffer with One-Shot Delay Setting

The block sits between a 32-channel system-side byte stream and a 24-timeslot DS1 transmit stream. It keeps one frame of timeslot octets. Bytes arrive with a channel index. A fixed mapping keeps 24 of the 32 system channels and drops the other 8. On the DS1 side, a free-running bit-position counter runs over a 193-bit frame: one framing bit followed by 24 octets. The counter fetches each stored octet at the start of its timeslot.

Both sides run on one clock. A write strobe marks each system byte, and a bit-tick strobe advances the DS1 side by one bit period. Software writes an 8-bit delay value to arm a single realignment. The next write that lands in timeslot 0 starts a count of DS1 bit ticks. When the count reaches the programmed value, the DS1 frame boundary is moved so that timeslot 0 is read on that tick. The frame then runs freely again. The delay from writing timeslot 0 to reading it is therefore set once, and it is always shorter than one frame.

Top module: `tx_slip_buffer`

## Requirements
- R1: After reset every output is 0 and every stored octet is 0. The first bit tick after reset reads timeslot 0 with data 0.
- R2: A write on system channel c (0..31) is stored in timeslot c - floor(c/4) - 1 when c mod 4 is not 0. A write on a channel that is a multiple of 4 is discarded and changes no stored octet.
- R3: Each bit tick advances the position by one, from 0 to 192 and then back to 0. On the tick that enters position 0, `tx_frame_o` pulses for one cycle. On the tick that enters position 1+8k, `tx_rd_stb_o` pulses for one cycle with `tx_rd_slot_o`=k and the octet of timeslot k. Neither output pulses in a cycle without a tick.
- R4: After a non-zero delay value D is written, the next write to timeslot 0 arms a count. On the D-th bit tick after the cycle of that write, the position is forced to 1, so timeslot 0 is read on that tick. From then on, frames follow every 193 ticks.
- R5: A delay value above 192 acts as 192, so the realigned read always falls within one frame of the write.
- R6: Writing delay value 0 is ignored. Any pending or previous setting is kept, and the frame is not moved.
- R7: A realignment happens once per delay write. Later writes to timeslot 0 do not move the frame until a new non-zero value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both sides |
| rst_ni | input | 1 | Active-low synchronous reset |
| sys_wr_en_i | input | 1 | System byte write strobe |
| sys_wr_ch_i | input | 5 | System channel index of the byte |
| sys_wr_data_i | input | 8 | System byte |
| dly_we_i | input | 1 | Delay register write strobe |
| dly_val_i | input | 8 | Delay value in DS1 bit periods |
| bit_tick_i | input | 1 | One DS1 bit period elapsed |
| tx_rd_stb_o | output | 1 | Timeslot octet is presented |
| tx_rd_slot_o | output | 5 | Index of the presented timeslot |
| tx_rd_data_o | output | 8 | Presented octet |
| tx_frame_o | output | 1 | Framing-bit position entered |

## Verification
The bench picks starting positions where a realignment and a free-running read of timeslot 0 cannot coincide. A design that counts the delay from the wrong tick, or that never moves the boundary, therefore reads the wrong timeslot at the expected tick. It writes the dropped channels (0 and 4) after their neighbours. A mapping off by one would overwrite timeslot 0 or 3. It writes the delay value 250, and also a zero written after a valid value. A missing clamp would read too late, and a zero that is not ignored would lose the realignment. Finally it writes timeslot 0 again after a realignment. A design that realigns every time would shift the next framing pulse away from its 193-tick spacing.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    RA_IDLE  = 2'd0,
    RA_ARMED = 2'd1,
    RA_COUNT = 2'd2
  } ra_state_e;

  // true when a system channel carries a DS1 timeslot
  function automatic bit ch_carries_slot(input int unsigned ch, input int unsigned group);
    return (ch % group) != 0;
  endfunction

  // timeslot index reached by a payload channel
  function automatic int unsigned ch_slot(input int unsigned ch, input int unsigned group);
    if ((ch % group) == 0) return 0;
    return ch - ch / group - 1;
  endfunction

  // limit a requested delay so the read stays inside one frame
  function automatic int unsigned clamp_dly(input int unsigned req, input int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

  // bit position where a timeslot octet begins
  function automatic bit pos_starts_slot(input int unsigned pos, input int unsigned slot_bits);
    return (pos != 0) && (((pos - 1) % slot_bits) == 0);
  endfunction

  function automatic int unsigned pos_slot(input int unsigned pos, input int unsigned slot_bits);
    return (pos == 0) ? 0 : (pos - 1) / slot_bits;
  endfunction

endpackage

// File: rtl/tsb_chan_map.sv
module tsb_chan_map #(
  parameter int NUM_CH = 32,
  parameter int NUM_TS = 24,
  parameter int CH_W   = 5,
  parameter int TS_W   = 5
) (
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  output logic            hit_o,
  output logic [TS_W-1:0] slot_o
);
  import tsb_pkg::*;

  localparam int GROUP = NUM_CH / (NUM_CH - NUM_TS);

  logic [NUM_CH-1:0] hit_tab;
  logic [TS_W-1:0]   slot_tab [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tab
    assign hit_tab[c]  = ch_carries_slot(c, GROUP);
    assign slot_tab[c] = TS_W'(ch_slot(c, GROUP));
  end

  assign hit_o  = wr_en_i && hit_tab[wr_ch_i];
  assign slot_o = slot_tab[wr_ch_i];

endmodule

// File: rtl/tsb_store.sv
module tsb_store #(
  parameter int NUM_TS = 24,
  parameter int TS_W   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TS_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TS_W-1:0]   raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [NUM_TS];

  for (genvar s = 0; s < NUM_TS; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        mem[s] <= '0;
      end else if (we_i && (waddr_i == TS_W'(s))) begin
        mem[s] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/tsb_realign.sv
module tsb_realign #(
  parameter int FRAME_BITS = 193,
  parameter int DLY_W      = 8,
  parameter int POS_W      = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [DLY_W-1:0]     cfg_val_i,
  input  logic                 slot0_wr_i,
  input  logic                 tick_i,
  output logic                 fire_o,
  output tsb_pkg::ra_state_e   state_o,
  output logic [POS_W-1:0]     dly_o
);
  import tsb_pkg::*;

  localparam int MAX_DLY = FRAME_BITS - 1;

  ra_state_e        state_q;
  logic [POS_W-1:0] dly_q;
  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] cnt_nx;
  logic [POS_W-1:0] dly_clamped;
  logic             cfg_ok;

  assign cfg_ok      = cfg_we_i && (cfg_val_i != '0);
  assign dly_clamped = POS_W'(clamp_dly(32'(cfg_val_i), MAX_DLY));
  assign cnt_nx      = cnt_q + 1'b1;
  assign fire_o      = (state_q == RA_COUNT) && tick_i && !cfg_ok && (cnt_nx == dly_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= RA_IDLE;
      dly_q   <= '0;
      cnt_q   <= '0;
    end else if (cfg_ok) begin
      dly_q   <= dly_clamped;
      state_q <= RA_ARMED;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RA_ARMED: begin
          if (slot0_wr_i) begin
            state_q <= RA_COUNT;
            cnt_q   <= '0;
          end
        end
        RA_COUNT: begin
          if (tick_i) begin
            if (fire_o) begin
              state_q <= RA_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_nx;
            end
          end
        end
        default: begin
          state_q <= RA_IDLE;
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign dly_o   = dly_q;

endmodule

// File: rtl/tsb_ds1_timer.sv
module tsb_ds1_timer #(
  parameter int FRAME_BITS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int POS_W      = 8,
  parameter int TS_W       = 5,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fire_i,
  output logic [TS_W-1:0]   rd_addr_o,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              rd_stb_o,
  output logic [TS_W-1:0]   rd_slot_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              frame_o
);
  import tsb_pkg::*;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  logic             slot_start;

  always_comb begin
    if (fire_i) begin
      pos_nx = POS_W'(1);
    end else if (pos_q == POS_W'(FRAME_BITS - 1)) begin
      pos_nx = '0;
    end else begin
      pos_nx = pos_q + 1'b1;
    end
  end

  assign slot_start = pos_starts_slot(32'(pos_nx), SLOT_BITS);
  assign rd_addr_o  = TS_W'(pos_slot(32'(pos_nx), SLOT_BITS));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      rd_stb_o  <= 1'b0;
      rd_slot_o <= '0;
      rd_data_o <= '0;
      frame_o   <= 1'b0;
    end else if (tick_i) begin
      pos_q    <= pos_nx;
      rd_stb_o <= slot_start;
      frame_o  <= (pos_nx == '0);
      if (slot_start) begin
        rd_slot_o <= rd_addr_o;
        rd_data_o <= rd_word_i;
      end
    end else begin
      rd_stb_o <= 1'b0;
      frame_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_slip_buffer.sv
module tx_slip_buffer #(
  parameter int NUM_CH    = 32,
  parameter int NUM_TS    = 24,
  parameter int SLOT_BITS = 8,
  parameter int DLY_W     = 8,
  parameter int CH_W      = $clog2(NUM_CH),
  parameter int TS_W      = $clog2(NUM_TS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sys_wr_en_i,
  input  logic [CH_W-1:0]      sys_wr_ch_i,
  input  logic [SLOT_BITS-1:0] sys_wr_data_i,
  input  logic                 dly_we_i,
  input  logic [DLY_W-1:0]     dly_val_i,
  input  logic                 bit_tick_i,
  output logic                 tx_rd_stb_o,
  output logic [TS_W-1:0]      tx_rd_slot_o,
  output logic [SLOT_BITS-1:0] tx_rd_data_o,
  output logic                 tx_frame_o
);
  import tsb_pkg::*;

  localparam int FRAME_BITS = 1 + NUM_TS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic                 map_hit;
  logic [TS_W-1:0]      map_slot;
  logic                 slot0_wr;
  logic                 fire;
  ra_state_e            ra_state;
  logic [POS_W-1:0]     dly_q;
  logic [TS_W-1:0]      rd_addr;
  logic [SLOT_BITS-1:0] rd_word;

  tsb_chan_map #(
    .NUM_CH(NUM_CH), .NUM_TS(NUM_TS), .CH_W(CH_W), .TS_W(TS_W)
  ) u_map (
    .wr_en_i(sys_wr_en_i),
    .wr_ch_i(sys_wr_ch_i),
    .hit_o  (map_hit),
    .slot_o (map_slot)
  );

  assign slot0_wr = map_hit && (map_slot == '0);

  tsb_store #(
    .NUM_TS(NUM_TS), .TS_W(TS_W), .DATA_W(SLOT_BITS)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (map_hit),
    .waddr_i(map_slot),
    .wdata_i(sys_wr_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_word)
  );

  tsb_realign #(
    .FRAME_BITS(FRAME_BITS), .DLY_W(DLY_W), .POS_W(POS_W)
  ) u_realign (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (dly_we_i),
    .cfg_val_i (dly_val_i),
    .slot0_wr_i(slot0_wr),
    .tick_i    (bit_tick_i),
    .fire_o    (fire),
    .state_o   (ra_state),
    .dly_o     (dly_q)
  );

  tsb_ds1_timer #(
    .FRAME_BITS(FRAME_BITS), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W),
    .TS_W(TS_W), .DATA_W(SLOT_BITS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bit_tick_i),
    .fire_i   (fire),
    .rd_addr_o(rd_addr),
    .rd_word_i(rd_word),
    .rd_stb_o (tx_rd_stb_o),
    .rd_slot_o(tx_rd_slot_o),
    .rd_data_o(tx_rd_data_o),
    .frame_o  (tx_frame_o)
  );

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int NUM_TS     = 24,
  parameter int FRAME_BITS = 193,
  parameter int TS_W       = 5,
  parameter int DLY_W      = 8,
  parameter int POS_W      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_tick_i,
  input logic               dly_we_i,
  input logic [DLY_W-1:0]   dly_val_i,
  input logic               fire,
  input tsb_pkg::ra_state_e ra_state,
  input logic [POS_W-1:0]   dly_q,
  input logic               tx_rd_stb_o,
  input logic [TS_W-1:0]    tx_rd_slot_o,
  input logic               tx_frame_o
);
  import tsb_pkg::*;

  // R3
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rd_stb_o |-> (tx_rd_slot_o < TS_W'(NUM_TS)));

  // R3
  frame_vs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_rd_stb_o && tx_frame_o));

  // R3
  no_tick_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> (!tx_rd_stb_o && !tx_frame_o));

  // R4
  realign_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (tx_rd_stb_o && (tx_rd_slot_o == '0)));

  // R5
  delay_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_state != RA_IDLE) |-> ((dly_q != '0) && (dly_q <= POS_W'(FRAME_BITS - 1))));

  // R6
  zero_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_we_i && (dly_val_i == '0) && (ra_state == RA_IDLE)) |=> (ra_state == RA_IDLE));

  // R7
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (ra_state == RA_IDLE));

endmodule

bind tx_slip_buffer tsb_checker #(
  .NUM_TS(NUM_TS), .FRAME_BITS(FRAME_BITS), .TS_W(TS_W), .DLY_W(DLY_W), .POS_W(POS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_tick_i  (bit_tick_i),
  .dly_we_i    (dly_we_i),
  .dly_val_i   (dly_val_i),
  .fire        (fire),
  .ra_state    (ra_state),
  .dly_q       (dly_q),
  .tx_rd_stb_o (tx_rd_stb_o),
  .tx_rd_slot_o(tx_rd_slot_o),
  .tx_frame_o  (tx_frame_o)
);

// File: tb/tb_tx_slip_buffer.sv
`timescale 1ns/1ps
module tb_tx_slip_buffer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic       dly_we = 1'b0;
  logic [7:0] dly_val = '0;
  logic       tick = 1'b0;
  logic       rd_stb;
  logic [4:0] rd_slot;
  logic [7:0] rd_data;
  logic       frame;

  int total = 0;
  int bad = 0;
  int gt = 0;
  int last_frame_at = -1;
  int last_ts0_at = -1;
  int last_ts0_data = -1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tx_slip_buffer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sys_wr_en_i(wr_en), .sys_wr_ch_i(wr_ch), .sys_wr_data_i(wr_data),
    .dly_we_i(dly_we), .dly_val_i(dly_val), .bit_tick_i(tick),
    .tx_rd_stb_o(rd_stb), .tx_rd_slot_o(rd_slot), .tx_rd_data_o(rd_data),
    .tx_frame_o(frame)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    tick = t;
    @(posedge clk);
    #1;
    if (t) gt++;
    if (frame) last_frame_at = gt;
    if (rd_stb && rd_slot == 5'd0) begin
      last_ts0_at = gt;
      last_ts0_data = int'(rd_data);
    end
    tick = 1'b0;
    wr_en = 1'b0;
    dly_we = 1'b0;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic wr(input int ch, input int d);
    wr_en = 1'b1;
    wr_ch = 5'(ch);
    wr_data = 8'(d);
    cyc(1'b0);
  endtask

  task automatic cfg(input int v);
    dly_we = 1'b1;
    dly_val = 8'(v);
    cyc(1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc(1'b0);
    rst_n = 1'b1;
    gt = 0;
    last_frame_at = -1;
    last_ts0_at = -1;
    last_ts0_data = -1;
  endtask

  // R1: reset state and first read
  task automatic t_reset();
    do_reset();
    chk(rd_stb == 1'b0, "R1", rd_stb, 0, "rd_stb after reset");
    chk(frame == 1'b0, "R1", frame, 0, "frame after reset");
    chk(rd_data == 8'd0 && rd_slot == 5'd0, "R1", rd_data, 0, "data after reset");
    cyc(1'b1);
    chk(rd_stb == 1'b1 && rd_slot == 5'd0, "R1", rd_slot, 0, "first tick slot");
    chk(rd_data == 8'd0, "R1", rd_data, 0, "first tick data");
  endtask

  // R2 and R3: mapping, dropped channels, free-running sequence
  task automatic t_map_seq();
    int errs_seq;
    int errs_map;
    do_reset();
    for (int c = 0; c < 32; c++) wr(c, (c * 7 + 3) & 255);
    wr(4, 8'hEE);
    wr(0, 8'hEE);
    errs_seq = 0;
    errs_map = 0;
    for (int p = 1; p <= 193; p++) begin
      cyc(1'b1);
      if (p == 193) begin
        chk(frame == 1'b1 && rd_stb == 1'b0, "R3", frame, 1, "frame at position 0");
      end else if (((p - 1) % 8) == 0) begin
        int k;
        int ch;
        k = (p - 1) / 8;
        ch = k + k / 3 + 1;
        if (!(rd_stb && int'(rd_slot) == k)) begin
          errs_seq++;
          chk(1'b0, "R3", rd_slot, k, "slot at slot start");
        end
        if (int'(rd_data) != ((ch * 7 + 3) & 255)) begin
          errs_map++;
          chk(1'b0, "R2", rd_data, (ch * 7 + 3) & 255, "octet of slot");
        end
      end else if (rd_stb || frame) begin
        errs_seq++;
        chk(1'b0, "R3", rd_stb, 0, "strobe inside slot");
      end
    end
    chk(errs_seq == 0, "R3", errs_seq, 0, "sequence errors");
    chk(errs_map == 0, "R2", errs_map, 0, "mapping errors");
    cyc(1'b0);
    chk(rd_stb == 1'b0 && frame == 1'b0, "R3", rd_stb, 0, "quiet without tick");
  endtask

  // R4 and R7: realign with delay 15, then one-shot
  task automatic t_delay();
    int g0;
    do_reset();
    cfg(15);
    adv(50);
    wr(1, 8'h5A);
    g0 = gt;
    adv(15);
    chk(last_ts0_at == g0 + 15, "R4", last_ts0_at, g0 + 15, "realigned ts0 tick");
    chk(last_ts0_data == 8'h5A, "R4", last_ts0_data, 8'h5A, "realigned ts0 data");
    adv(192);
    chk(last_frame_at == g0 + 15 + 192, "R4", last_frame_at, g0 + 207, "frame after realign");
    wr(1, 8'h11);
    adv(193);
    chk(last_frame_at == g0 + 15 + 385, "R7", last_frame_at, g0 + 400, "frame not moved again");
    chk(last_ts0_at == g0 + 15 + 193 && last_ts0_data == 8'h11, "R7", last_ts0_at, g0 + 208, "ts0 free-running");
  endtask

  // R5: clamp above 192
  task automatic t_clamp();
    int g0;
    do_reset();
    adv(10);
    cfg(250);
    wr(1, 8'h77);
    g0 = gt;
    adv(192);
    chk(last_ts0_at == g0 + 192, "R5", last_ts0_at, g0 + 192, "clamped ts0 tick");
    chk(last_ts0_data == 8'h77, "R5", last_ts0_data, 8'h77, "clamped ts0 data");
  endtask

  // R6: zero ignored
  task automatic t_zero();
    int g0;
    do_reset();
    cfg(0);
    adv(5);
    wr(1, 8'h33);
    adv(188);
    chk(last_frame_at == 193, "R6", last_frame_at, 193, "zero write leaves frame");
    do_reset();
    cfg(20);
    cfg(0);
    adv(3);
    wr(1, 8'h44);
    g0 = gt;
    adv(20);
    chk(last_ts0_at == g0 + 20, "R6", last_ts0_at, g0 + 20, "previous setting kept");
    chk(last_ts0_data == 8'h44, "R6", last_ts0_data, 8'h44, "kept setting data");
  endtask

  initial begin
    t_reset();
    t_map_seq();
    t_delay();
    t_clamp();
    t_zero();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule